// File: doc/BRIEF.md
# Reset Release Sequencer

This block merges three reset sources into one active-low internal reset for the main logic domain. The sources are the supply-good signal from the power-on detector, the external active-low reset pin, and the supply-in-range signal from the low-voltage detector. The supply-good signal acts as the cold reset of the block itself. After it rises, a counter times a fixed initialization interval. The internal reset is released on the first clock edge after three things are all true: that interval has elapsed, the synchronized pin reads high, and the low-voltage signal has stayed good for a programmed release delay.

After release, the reset pin goes through a two-flop synchronizer and a low-pulse filter, so a short glitch is ignored and only a sustained low re-enters reset. A drop of the low-voltage signal also re-enters reset, and the release delay must run again in full before reset is released. Three sticky cause flags record which source caused a reset. A warm reset does not clear them. Software clears a flag by writing 1 to it. All timing parameters are counted in clock cycles of a free-running clock.

Top module: `rst_release_seq`

## Requirements
- R1: While `por_ok` is low, `sys_rst_n` is low and `cause_flags` reads 3'b001. Bit 0 is the power-on cause, bit 1 the pin cause and bit 2 the low-voltage cause.
- R2: After `por_ok` rises, count the clock edges from 1. If the pin is raised after edge p and `lvd_ok` after edge v, `sys_rst_n` rises at edge max(INIT_CYC, p+2, v+2+LVD_REL)+1. An input already high when `por_ok` rises counts as p=0 or v=0.
- R3: The reset is never released before edge INIT_CYC+1, however early the pin and the low-voltage input are good.
- R4: If the pin is still low when the initialization interval ends, reset stays asserted until 3 edges after the pin is raised.
- R5: If `lvd_ok` is still low when the initialization interval ends, release waits until LVD_REL+3 edges after `lvd_ok` rises.
- R6: While running, a pin low lasting PIN_MIN cycles or fewer has no effect on `sys_rst_n` or on flag bit 1. A low lasting PIN_MIN+1 cycles or longer pulls `sys_rst_n` low PIN_MIN+3 edges after the pin falls, and `sys_rst_n` returns high 3 edges after the pin rises.
- R7: While running, `lvd_ok` going low pulls `sys_rst_n` low 3 edges later. Release follows LVD_REL+3 edges after `lvd_ok` returns high.
- R8: Flag bit 1 is set when a filtered pin reset occurs, and flag bit 2 is set when the synchronized low-voltage signal falls. Warm resets do not clear either bit.
- R9: One cycle of `clr_we` high clears the flag bits selected by `clr_mask` at that edge. If a set event for a bit falls in the same cycle, the set wins.
- R10: A cold reset clears flag bits 1 and 2 and sets bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_ok | input | 1 | Supply-good from the power-on detector; low is a cold reset |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| lvd_ok | input | 1 | Supply above the low-voltage level, asynchronous |
| clr_we | input | 1 | Write strobe for clearing flags |
| clr_mask | input | 3 | Flags to clear, 1 per bit |
| sys_rst_n | output | 1 | Internal reset for the main domain, active low |
| cause_flags | output | 3 | Sticky reset-cause flags {lvd, pin, por} |

## Verification
Every input reaches the synchronizer's second flop two edges after it is driven. Reset release then needs one more register, and each release or filter delay adds its own count on top. So a release is due at an edge that is a closed-form sum of those counts, and a filtered pin fall is due PIN_MIN+3 edges after the pin falls. The bench counts edges from the edge just before each stimulus, samples on the falling clock edge, and records the first edge at which `sys_rst_n` changes. It then compares that edge number with the sum computed from the requirement. Cold starts are swept over every pair of pin and low-voltage release times in a small window. Pin pulses are swept across the filter threshold. Flags are read one edge after each clear strobe.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  localparam int CAUSE_W   = 3;
  localparam int CAUSE_POR = 0;
  localparam int CAUSE_PIN = 1;
  localparam int CAUSE_LVD = 2;

  // saturating increment used by every cycle timer
  function automatic int unsigned sat_next(int unsigned cur, int unsigned lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction

  // all three release conditions at once
  function automatic logic release_ok(logic init_done, logic lvd_done,
                                      logic pin_hi, logic pin_hold);
    return init_done & lvd_done & pin_hi & ~pin_hold;
  endfunction

  // sticky flags: clear selected bits, then OR in events (set wins)
  function automatic logic [CAUSE_W-1:0] next_flags(logic [CAUSE_W-1:0] cur,
                                                    logic [CAUSE_W-1:0] set,
                                                    logic [CAUSE_W-1:0] clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/rsq_sync2.sv
module rsq_sync2 #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic s1;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1 <= RST_VAL;
      q  <= RST_VAL;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/rsq_stable_timer.sv
module rsq_stable_timer #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic arst_n,
  input  logic go,
  output logic done
);
  import rsq_pkg::*;
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)  cnt <= '0;
    else if (!go) cnt <= '0;
    else          cnt <= CW'(sat_next(32'(cnt), LIMIT));
  end

  assign done = go && (cnt == CW'(LIMIT));

  // R6 R5: completion needs the qualifying input in the previous cycle too
  done_needs_go_chk: assert property (@(posedge clk) disable iff (!arst_n)
    done |-> $past(go));
endmodule

// File: rtl/rst_release_seq.sv
module rst_release_seq #(
  parameter int unsigned INIT_CYC = 8,
  parameter int unsigned LVD_REL  = 5,
  parameter int unsigned PIN_MIN  = 3
) (
  input  logic       clk,
  input  logic       por_ok,
  input  logic       rst_pin_n,
  input  logic       lvd_ok,
  input  logic       clr_we,
  input  logic [2:0] clr_mask,
  output logic       sys_rst_n,
  output logic [2:0] cause_flags
);
  import rsq_pkg::*;

  logic pin_s, lvd_s, lvd_prev;
  logic init_done, lvd_done, pin_hold;
  logic lvd_fall, rel_ok, run_hold;
  logic [CAUSE_W-1:0] flag_set, flag_clr;

  rsq_sync2 #(.RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .arst_n(por_ok), .d(rst_pin_n), .q(pin_s));
  rsq_sync2 #(.RST_VAL(1'b0)) u_lvd_sync (
    .clk(clk), .arst_n(por_ok), .d(lvd_ok), .q(lvd_s));

  rsq_stable_timer #(.LIMIT(INIT_CYC)) u_init_tmr (
    .clk(clk), .arst_n(por_ok), .go(1'b1), .done(init_done));
  rsq_stable_timer #(.LIMIT(LVD_REL)) u_lvd_tmr (
    .clk(clk), .arst_n(por_ok), .go(lvd_s), .done(lvd_done));
  rsq_stable_timer #(.LIMIT(PIN_MIN)) u_pin_filt (
    .clk(clk), .arst_n(por_ok), .go(~pin_s), .done(pin_hold));

  always_ff @(posedge clk or negedge por_ok) begin
    if (!por_ok) lvd_prev <= 1'b0;
    else         lvd_prev <= lvd_s;
  end

  assign lvd_fall = lvd_prev & ~lvd_s;
  assign rel_ok   = release_ok(init_done, lvd_done, pin_s, pin_hold);
  assign run_hold = pin_hold | ~lvd_done;

  always_ff @(posedge clk or negedge por_ok) begin
    if (!por_ok)        sys_rst_n <= 1'b0;
    else if (sys_rst_n) sys_rst_n <= ~run_hold;
    else                sys_rst_n <= rel_ok;
  end

  always_comb begin
    flag_set            = '0;
    flag_set[CAUSE_PIN] = pin_hold;
    flag_set[CAUSE_LVD] = lvd_fall;
    flag_clr            = clr_we ? clr_mask : '0;
  end

  always_ff @(posedge clk or negedge por_ok) begin
    if (!por_ok) cause_flags <= 3'b001;
    else         cause_flags <= next_flags(cause_flags, flag_set, flag_clr);
  end

  // R3: the initialization interval, once over, never restarts without a cold reset
  init_sticky_chk: assert property (@(posedge clk) disable iff (!por_ok)
    !$fell(init_done));

  // R2 R4 R5: reset is held until every release condition is met
  hold_until_ready_chk: assert property (@(posedge clk) disable iff (!por_ok)
    (!sys_rst_n && !rel_ok) |=> !sys_rst_n);

  // R6: a filtered pin low while running enters reset and records the pin cause
  pin_enter_chk: assert property (@(posedge clk) disable iff (!por_ok)
    (sys_rst_n && pin_hold) |=> (!sys_rst_n && cause_flags[CAUSE_PIN]));

  // R7 R8: a low-voltage drop enters reset and records its cause
  lvd_enter_chk: assert property (@(posedge clk) disable iff (!por_ok)
    lvd_fall |=> (!sys_rst_n && cause_flags[CAUSE_LVD]));

  // R9: the power-on flag has no set source after a cold start, so a clear sticks
  por_clear_chk: assert property (@(posedge clk) disable iff (!por_ok)
    (clr_we && clr_mask[CAUSE_POR]) |=> !cause_flags[CAUSE_POR]);
endmodule

// File: tb/rst_release_seq_tb.sv
module rst_release_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int INIT = 8;
  localparam int REL  = 5;
  localparam int PMIN = 3;

  logic clk = 1'b0;
  logic por_ok = 1'b0;
  logic rst_pin_n = 1'b1;
  logic lvd_ok = 1'b1;
  logic clr_we = 1'b0;
  logic [2:0] clr_mask = 3'b000;
  logic sys_rst_n;
  logic [2:0] cause_flags;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_release_seq #(.INIT_CYC(INIT), .LVD_REL(REL), .PIN_MIN(PMIN)) dut_i (
    .clk(clk), .por_ok(por_ok), .rst_pin_n(rst_pin_n), .lvd_ok(lvd_ok),
    .clr_we(clr_we), .clr_mask(clr_mask),
    .sys_rst_n(sys_rst_n), .cause_flags(cause_flags));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int max3(int a, int b, int c);
    int m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

  task automatic clear_flags(input logic [2:0] m);
    @(negedge clk);
    clr_we = 1'b1; clr_mask = m;
    @(negedge clk);
    clr_we = 1'b0; clr_mask = 3'b000;
  endtask

  // cold start: pin high after edge pin_n, lvd high after edge lvd_n (0 = high from start)
  task automatic cold_run(input int pin_n, input int lvd_n, input string req);
    int rel_k = -1;
    int exp_fl;
    por_ok = 1'b0; clr_we = 1'b0;
    rst_pin_n = (pin_n == 0);
    lvd_ok = (lvd_n == 0);
    @(negedge clk);
    chk("R1 reset level", int'(sys_rst_n), 0);
    chk("R1 reset flags", int'(cause_flags), 1);
    @(negedge clk);
    por_ok = 1'b1;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (rel_k < 0 && sys_rst_n) rel_k = k;
      if (k == pin_n) rst_pin_n = 1'b1;
      if (k == lvd_n) lvd_ok = 1'b1;
    end
    chk(req, rel_k, max3(INIT, pin_n + 2, lvd_n + 2 + REL) + 1);
    exp_fl = 1 + ((pin_n >= PMIN + 1) ? 2 : 0);
    chk("R8 R10 cold flags", int'(cause_flags), exp_fl);
  endtask

  task automatic pin_pulse(input int len);
    int fall_k = -1;
    int rise_k = -1;
    bit drop = (len >= PMIN + 1);
    clear_flags(3'b111);
    @(negedge clk);
    rst_pin_n = 1'b0;
    for (int k = 1; k <= len + PMIN + 12; k++) begin
      @(negedge clk);
      if (fall_k < 0 && !sys_rst_n) fall_k = k;
      if (fall_k >= 0 && rise_k < 0 && sys_rst_n) rise_k = k;
      if (k == len) rst_pin_n = 1'b1;
    end
    chk("R6 pin fall edge", fall_k, drop ? PMIN + 3 : -1);
    chk("R6 pin rise edge", rise_k, drop ? len + 3 : -1);
    chk("R6 R8 pin flag", int'(cause_flags[1]), int'(drop));
  endtask

  task automatic lvd_drop(input int len);
    int fall_k = -1;
    int rise_k = -1;
    @(negedge clk);
    lvd_ok = 1'b0;
    for (int k = 1; k <= len + REL + 12; k++) begin
      @(negedge clk);
      if (fall_k < 0 && !sys_rst_n) fall_k = k;
      if (fall_k >= 0 && rise_k < 0 && sys_rst_n) rise_k = k;
      if (k == len) lvd_ok = 1'b1;
    end
    chk("R7 lvd fall edge", fall_k, 3);
    chk("R7 lvd rise edge", rise_k, len + 3 + REL);
    chk("R8 lvd flag", int'(cause_flags[2]), 1);
  endtask

  initial begin
    // R2 R3 R4 R5: cold sweep over both release times
    for (int p = 0; p <= 12; p++)
      for (int v = 0; v <= 12; v++)
        cold_run(p, v, "R2 R3 R4 R5 release edge");

    // R6: pulses around the filter threshold
    for (int len = 1; len <= PMIN + 3; len++) pin_pulse(len);

    // R7 R8: low-voltage drops, flags survive warm reset
    clear_flags(3'b111);
    for (int d = 1; d <= 4; d++) lvd_drop(d);
    pin_pulse(PMIN + 2);
    chk("R8 flags after warm resets", int'(cause_flags), 3'b010);
    lvd_drop(2);
    chk("R8 both warm causes kept", int'(cause_flags), 3'b110);

    // R9: selective clear
    clear_flags(3'b010);
    chk("R9 clear pin bit only", int'(cause_flags), 3'b100);
    clear_flags(3'b100);
    chk("R9 clear lvd bit", int'(cause_flags), 3'b000);

    // R9: set wins over clear while the pin is still held low
    @(negedge clk);
    rst_pin_n = 1'b0;
    repeat (PMIN + 6) @(negedge clk);
    clear_flags(3'b010);
    chk("R9 set wins over clear", int'(cause_flags[1]), 1);
    rst_pin_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R4 released after pin high", int'(sys_rst_n), 1);
    clear_flags(3'b010);
    chk("R9 cleared after pin high", int'(cause_flags[1]), 0);

    // R10: cold reset after warm causes
    lvd_drop(1);
    cold_run(0, 0, "R10 cold release edge");
    chk("R10 cold flags only por", int'(cause_flags), 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule